// File: doc/BRIEF.md
# Accumulator and Link Micro-Operation Unit

This block is the datapath for the first operate group of a 12-bit accumulator machine. It takes a 9-bit micro-operation field, the current accumulator and the one-bit link. It works out the new accumulator and link. It also reports which of the two registers the instruction reads and which it writes. The micro-operations are clear, complement, increment, rotate through the link, and half-word swap. Each has its own bit in the field, so several can be combined in one instruction.

The micro-operations run in a fixed order: clear, then complement, then increment, then rotate or swap. The swap bit has two meanings. Next to a rotate it makes the rotate a double rotate. On its own it exchanges the accumulator halves. Setting both rotate directions cancels the rotate.

A registered stage sits behind the combinational logic. On a valid strobe it captures the result, and it raises a done flag in the following cycle. The read and write enables stay combinational from the field.

Top module: `accum_microop_unit`

## Requirements
- R1: When field bit 8 (octal 0400) is set, the field does not belong to this group. The accumulator and link are left unchanged and all four enables are low.
- R2: Bit 7 (0200) clears the accumulator and bit 6 (0100) clears the link. Clearing happens before every other micro-operation.
- R3: Bit 5 (0040) inverts the accumulator and bit 4 (0020) inverts the link. Both act after clearing, so clear plus invert gives all ones.
- R4: Bit 0 (0001) adds one to the 12-bit accumulator after the complement step. When the sum wraps to zero, the link toggles.
- R5: Bit 3 (0010) rotates right and bit 2 (0004) rotates left. The rotate works on the 13-bit value {link, accumulator}, with the link as bit 12. It moves that value one place, after the increment step.
- R6: When bit 1 (0002) is set together with exactly one rotate bit, the rotate is done twice.
- R7: When both rotate bits are set, neither a rotate nor a swap takes place, whatever bit 1 holds.
- R8: Bit 1 alone, with no rotate bit, exchanges accumulator bits [5:0] with bits [11:6]. The link is unchanged.
- R9: Accumulator read is high for complement, rotate, swap or increment. Link read is high for link complement, rotate or increment. Accumulator write is high for clear, complement, rotate, swap or increment. Link write is high for link clear, link complement, rotate or increment.
- R10: After reset the registered accumulator, link and done flag are zero. A high `in_valid` loads the result at the clock edge, and `done` is high during the next cycle only. Without `in_valid` the registered outputs hold.
- R11: A field of zero is a no-operation. The registered accumulator and link take the input values unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Strobe that loads the result |
| op_field | input | 9 | Micro-operation field |
| acc_in | input | 12 | Current accumulator |
| link_in | input | 1 | Current link |
| acc_out | output | 12 | Registered new accumulator |
| link_out | output | 1 | Registered new link |
| done | output | 1 | High one cycle after a strobe |
| rd_acc | output | 1 | Instruction reads the accumulator |
| rd_link | output | 1 | Instruction reads the link |
| wr_acc | output | 1 | Instruction writes the accumulator |
| wr_link | output | 1 | Instruction writes the link |

## Verification
The bench aims at the points where the micro-operations interact.

- **Clear plus complement.** A design that ran these in the wrong order would return zero instead of all ones.
- **Complement plus increment on zero.** This wraps to zero. A design that lost the link toggle would show the link unchanged.
- **Swap with a rotate.** A design that ignored the double rotate would move the value by only one place.
- **Swap with both rotate bits.** A design that treated this as a plain swap would exchange the halves.
- **Field with bit 8 set.** A design that decoded it anyway would alter the registers or raise enables.

Random fields then mix all the bits against a bench model.

// File: rtl/accum_microop_unit.sv
module accum_microop_unit #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [8:0]   op_field,
  input  logic [W-1:0] acc_in,
  input  logic         link_in,
  output logic [W-1:0] acc_out,
  output logic         link_out,
  output logic         done,
  output logic         rd_acc,
  output logic         rd_link,
  output logic         wr_acc,
  output logic         wr_link
);
  localparam int H = W / 2;
  localparam int T = W + 1;

  logic sel;
  logic clr_a, clr_l, inv_a, inv_l, rot_r, rot_l, swp, inc;
  assign sel   = ~op_field[8];
  assign clr_a = sel & op_field[7];
  assign clr_l = sel & op_field[6];
  assign inv_a = sel & op_field[5];
  assign inv_l = sel & op_field[4];
  assign rot_r = sel & op_field[3];
  assign rot_l = sel & op_field[2];
  assign swp   = sel & op_field[1];
  assign inc   = sel & op_field[0];

  logic one_rot;
  assign one_rot = rot_r ^ rot_l;

  assign rd_acc  = inv_a | rot_r | rot_l | swp | inc;
  assign rd_link = inv_l | rot_r | rot_l | inc;
  assign wr_acc  = clr_a | inv_a | rot_r | rot_l | swp | inc;
  assign wr_link = clr_l | inv_l | rot_r | rot_l | inc;

  logic [W-1:0] a1, a2;
  logic         l1, l2;
  logic [T-1:0] v, v1, v2, res;

  always_comb begin
    a1 = clr_a ? '0 : acc_in;
    l1 = clr_l ? 1'b0 : link_in;
    if (inv_a) a1 = ~a1;
    if (inv_l) l1 = ~l1;
    a2 = a1 + (inc ? W'(1) : W'(0));
    l2 = l1 ^ (inc & (a2 == '0));
    v  = {l2, a2};
    v1 = rot_r ? {v[0], v[T-1:1]} : {v[T-2:0], v[T-1]};
    v2 = rot_r ? {v1[0], v1[T-1:1]} : {v1[T-2:0], v1[T-1]};
    if (one_rot)
      res = swp ? v2 : v1;
    else if (swp && !rot_r && !rot_l)
      res = {l2, a2[H-1:0], a2[W-1:H]};
    else
      res = v;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_out  <= '0;
      link_out <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= in_valid;
      if (in_valid) begin
        acc_out  <= res[W-1:0];
        link_out <= res[T-1];
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> done);  // R10
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(acc_out) && $stable(link_out));  // R10
  AST_NOP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_field == 9'o000) |=> (acc_out == $past(acc_in)) && (link_out == $past(link_in)));  // R11
  AST_OTHER_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_field[8]) |=> (acc_out == $past(acc_in)) && (link_out == $past(link_in)));  // R1
  AST_CLEAR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_field == 9'o300) |=> (acc_out == '0) && !link_out);  // R2
  AST_READ_IMPLIES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |-> wr_acc);  // R9
endmodule

// File: tb/accum_microop_unit_tb.sv
module accum_microop_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [8:0]  op_field = '0;
  logic [11:0] acc_in = '0;
  logic        link_in = 1'b0;
  logic [11:0] acc_out;
  logic        link_out, done, rd_acc, rd_link, wr_acc, wr_link;
  int n_checks = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  accum_microop_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_field(op_field),
    .acc_in(acc_in), .link_in(link_in), .acc_out(acc_out), .link_out(link_out),
    .done(done), .rd_acc(rd_acc), .rd_link(rd_link), .wr_acc(wr_acc), .wr_link(wr_link)
  );

  function automatic logic [12:0] model(input logic [8:0] op, input logic [11:0] a, input logic l);
    logic [12:0] x;
    if (op[8]) return {l, a};
    if (op[7]) a = 12'o0;
    if (op[6]) l = 1'b0;
    if (op[5]) a = ~a;
    if (op[4]) l = ~l;
    if (op[0]) begin
      a = a + 12'd1;
      if (a == 12'o0) l = ~l;
    end
    x = {l, a};
    if (op[3] != op[2]) begin
      for (int k = 0; k < (op[1] ? 2 : 1); k++)
        x = op[3] ? {x[0], x[12:1]} : {x[11:0], x[12]};
    end else if (op[1] && !op[3] && !op[2]) begin
      x = {l, a[5:0], a[11:6]};
    end
    return x;
  endfunction

  function automatic logic [3:0] model_en(input logic [8:0] op);
    logic ra, rl, wa, wl;
    if (op[8]) return 4'b0000;
    ra = op[5] | op[3] | op[2] | op[1] | op[0];
    rl = op[4] | op[3] | op[2] | op[0];
    wa = op[7] | ra;
    wl = op[6] | op[4] | op[3] | op[2] | op[0];
    return {ra, rl, wa, wl};
  endfunction

  task automatic check(input string req, input string what, input logic [15:0] got, input logic [15:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %o expected %o", req, what, got, exp);
    end
  endtask

  task automatic run_op(input string req, input logic [8:0] op, input logic [11:0] a, input logic l);
    logic [12:0] e;
    e = model(op, a, l);
    @(negedge clk);
    op_field = op; acc_in = a; link_in = l; in_valid = 1'b1;
    #1;
    check("R9", "enables", {12'd0, rd_acc, rd_link, wr_acc, wr_link}, {12'd0, model_en(op)});
    @(negedge clk);
    in_valid = 1'b0;
    check(req, "result", {3'd0, link_out, acc_out}, {3'd0, e});
    check("R10", "done", {15'd0, done}, 16'd1);
  endtask

  initial begin
    #400000;
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd41));
    repeat (3) @(negedge clk);
    check("R10", "reset acc", {4'd0, acc_out}, 16'd0);
    check("R10", "reset link", {15'd0, link_out}, 16'd0);
    check("R10", "reset done", {15'd0, done}, 16'd0);
    rst_n = 1'b1;
    run_op("R11", 9'o000, 12'o5252, 1'b1);
    run_op("R2", 9'o300, 12'o1234, 1'b1);
    run_op("R3", 9'o240, 12'o1234, 1'b0);
    run_op("R3", 9'o120, 12'o0000, 1'b0);
    run_op("R4", 9'o001, 12'o7777, 1'b0);
    run_op("R4", 9'o041, 12'o0000, 1'b1);
    run_op("R5", 9'o010, 12'o0001, 1'b0);
    run_op("R5", 9'o004, 12'o4000, 1'b0);
    run_op("R5", 9'o205, 12'o1111, 1'b1);
    run_op("R6", 9'o012, 12'o0001, 1'b0);
    run_op("R6", 9'o006, 12'o6000, 1'b0);
    run_op("R7", 9'o014, 12'o1357, 1'b1);
    run_op("R7", 9'o016, 12'o1234, 1'b0);
    run_op("R8", 9'o002, 12'o1234, 1'b1);
    run_op("R1", 9'o777, 12'o4321, 1'b1);
    run_op("R1", 9'o400, 12'o0000, 1'b0);
    @(negedge clk);
    check("R10", "done drop", {15'd0, done}, 16'd0);
    acc_in = 12'o7070; op_field = 9'o200;
    @(negedge clk);
    check("R10", "hold acc", {4'd0, acc_out}, 16'o0000);
    for (int i = 0; i < 400; i++) begin
      logic [8:0] op;
      op = 9'($urandom);
      if (i % 4 != 0) op[8] = 1'b0;
      run_op("R5", op, 12'($urandom), 1'($urandom));
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule